// File: doc/BRIEF.md
# Aligned Memory Signature Scanner

This block searches a fixed physical address window, 0xF0000 through 0xFFFFF inclusive, for a four-byte marker. The marker may only start on an address that is a multiple of 16, and it is the ASCII text "_MP_". When the marker is found, the 32-bit value held in the next four bytes is taken as a physical table address and captured. Candidates are visited in ascending order and the search ends at the first hit.

The scanner reads memory one 32-bit word at a time through a small request/response port. It issues one request and then waits for the response before it issues the next. A single-cycle `start` pulse launches a scan. The results (`found`, `match_addr`, `table_ptr`) are held with `done` until software or a sequencer pulses `start` again. The block does not verify checksums and does not parse the table it points at.

Top module: `sigscan_top`

## Requirements
- R1: While and right after reset, `busy`, `done`, `found` and `mem_req` are 0 and `match_addr` and `table_ptr` are 0.
- R2: A `start` pulse seen while no scan is running begins a scan. In the next cycle `busy` is 1, `done` is 0, and `mem_req` is 1 with `mem_addr` = 0xF0000.
- R3: Signature reads go only to addresses with the low four bits zero, from 0xF0000 up to 0xFFFF0, in steps of 16. Words are little-endian, so the marker word is 0x5F504D5F (byte 0x5F "_" at the lowest address, then 0x4D, 0x50, 0x5F).
- R4: `mem_req` is a one-cycle pulse. No new request is issued until `mem_rvalid` has answered the previous one. A response arrives no earlier than the cycle after its request.
- R5: On a marker hit at candidate A, the next read goes to A+4. When that read returns, `table_ptr` holds its word, `match_addr` = A, `found` = 1 and `done` = 1.
- R6: When several aligned candidates carry the marker, the lowest address wins.
- R7: If the read at 0xFFFF0 misses, `done` rises with `found` = 0 after exactly 4096 reads.
- R8: A word that differs from 0x5F504D5F in any bit is not a hit. This includes the byte-reversed marker 0x5F4D505F. A marker placed at an address that is not a multiple of 16, or outside the window, is never found.
- R9: After completion, `done`, `found`, `match_addr` and `table_ptr` stay unchanged until the next `start`.
- R10: A `start` pulse during a running scan is ignored. The scan continues with the same addresses and the same result.
- R11: The result does not depend on response latency (zero to several wait cycles).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan launch pulse |
| mem_req | output | 1 | Read request pulse |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_rdata | input | DATA_W | Read data, little-endian |
| mem_rvalid | input | 1 | Read data valid |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished, results valid |
| found | output | 1 | Marker located |
| match_addr | output | ADDR_W | Address of the matching candidate |
| table_ptr | output | DATA_W | Word read right after the marker |

## Verification
A wrong candidate counter shows up at the ports as a total read count that departs from (A−0xF0000)/16+2 for a hit at A, or from 4096 for a miss. It also shows as a wrong `match_addr` as soon as `done` rises.

A faulty comparator either accepts a near-miss or byte-swapped word, or skips a real marker. Either way `found` is wrong at the end of that scan.

A sequencing fault shows within one or two cycles. It appears as a request issued while another is outstanding, a request held high for two cycles, or `done` dropping without a `start`.

// File: rtl/sigscan_pkg.sv
package sigscan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SIG    = 2'd1,
    ST_PTR    = 2'd2,
    ST_FINISH = 2'd3
  } scan_state_t;
endpackage

// File: rtl/sigscan_cand_ctr.sv
module sigscan_cand_ctr #(
  parameter int unsigned ADDR_W   = 20,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hF0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 20'hFFFF0,
  parameter int unsigned STRIDE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              adv,
  output logic [ADDR_W-1:0] cand,
  output logic [ADDR_W-1:0] cand_next,
  output logic              at_last
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(STRIDE);

  assign cand_next = cand + STEP;
  assign at_last   = (cand == WIN_LAST);

  always_ff @(posedge clk) begin
    if (rst)       cand <= WIN_BASE;
    else if (load) cand <= WIN_BASE;
    else if (adv)  cand <= cand_next;
  end
endmodule

// File: rtl/sigscan_word_cmp.sv
module sigscan_word_cmp #(
  parameter int unsigned DATA_W = 32,
  parameter logic [DATA_W-1:0] SIGNATURE = 32'h5F504D5F
) (
  input  logic [DATA_W-1:0] word,
  output logic              hit
);
  localparam int unsigned NBYTES = DATA_W / 8;
  logic [NBYTES-1:0] byte_eq;

  for (genvar i = 0; i < NBYTES; i++) begin : g_byte
    assign byte_eq[i] = (word[8*i +: 8] == SIGNATURE[8*i +: 8]);
  end

  assign hit = &byte_eq;
endmodule

// File: rtl/sigscan_ctrl.sv
module sigscan_ctrl
  import sigscan_pkg::*;
#(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hF0000,
  parameter int unsigned PTR_OFFSET = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              rvalid,
  input  logic [DATA_W-1:0] rdata,
  input  logic              hit,
  input  logic [ADDR_W-1:0] cand,
  input  logic [ADDR_W-1:0] cand_next,
  input  logic              at_last,
  output logic              load,
  output logic              adv,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] match_addr,
  output logic [DATA_W-1:0] table_ptr
);
  localparam logic [ADDR_W-1:0] PTR_OFS = ADDR_W'(PTR_OFFSET);

  scan_state_t state;
  logic        launch;

  assign launch = start && (state == ST_IDLE || state == ST_FINISH);
  assign load   = launch;
  assign adv    = (state == ST_SIG) && rvalid && !hit && !at_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      busy       <= 1'b0;
      done       <= 1'b0;
      found      <= 1'b0;
      match_addr <= '0;
      table_ptr  <= '0;
    end else begin
      mem_req <= 1'b0;
      case (state)
        ST_IDLE, ST_FINISH: begin
          if (launch) begin
            state      <= ST_SIG;
            mem_req    <= 1'b1;
            mem_addr   <= WIN_BASE;
            busy       <= 1'b1;
            done       <= 1'b0;
            found      <= 1'b0;
            match_addr <= '0;
            table_ptr  <= '0;
          end
        end
        ST_SIG: begin
          if (rvalid) begin
            if (hit) begin
              state      <= ST_PTR;
              mem_req    <= 1'b1;
              mem_addr   <= cand + PTR_OFS;
              match_addr <= cand;
            end else if (at_last) begin
              state <= ST_FINISH;
              busy  <= 1'b0;
              done  <= 1'b1;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= cand_next;
            end
          end
        end
        ST_PTR: begin
          if (rvalid) begin
            state     <= ST_FINISH;
            table_ptr <= rdata;
            found     <= 1'b1;
            busy      <= 1'b0;
            done      <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sigscan_top.sv
module sigscan_top #(
  parameter int unsigned ADDR_W     = 20,
  parameter int unsigned DATA_W     = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hF0000,
  parameter logic [ADDR_W-1:0] WIN_LAST = 20'hFFFF0,
  parameter int unsigned STRIDE     = 16,
  parameter int unsigned PTR_OFFSET = 4,
  parameter logic [DATA_W-1:0] SIGNATURE = 32'h5F504D5F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rvalid,
  output logic              busy,
  output logic              done,
  output logic              found,
  output logic [ADDR_W-1:0] match_addr,
  output logic [DATA_W-1:0] table_ptr
);
  logic              load, adv, at_last, hit;
  logic [ADDR_W-1:0] cand, cand_next;

  sigscan_cand_ctr #(
    .ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LAST(WIN_LAST), .STRIDE(STRIDE)
  ) u_ctr (
    .clk(clk), .rst(rst), .load(load), .adv(adv),
    .cand(cand), .cand_next(cand_next), .at_last(at_last)
  );

  sigscan_word_cmp #(
    .DATA_W(DATA_W), .SIGNATURE(SIGNATURE)
  ) u_cmp (
    .word(mem_rdata), .hit(hit)
  );

  sigscan_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE), .PTR_OFFSET(PTR_OFFSET)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .rvalid(mem_rvalid), .rdata(mem_rdata),
    .hit(hit), .cand(cand), .cand_next(cand_next), .at_last(at_last),
    .load(load), .adv(adv), .mem_req(mem_req), .mem_addr(mem_addr),
    .busy(busy), .done(done), .found(found),
    .match_addr(match_addr), .table_ptr(table_ptr)
  );
endmodule

// File: rtl/sigscan_checker.sv
module sigscan_checker #(
  parameter int unsigned ADDR_W = 20,
  parameter int unsigned DATA_W = 32,
  parameter logic [ADDR_W-1:0] WIN_BASE = 20'hF0000
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              busy,
  input logic              done,
  input logic              found,
  input logic [ADDR_W-1:0] match_addr,
  input logic [DATA_W-1:0] table_ptr
);
  logic outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= 1'b0;
    else     outstanding_q <= (outstanding_q && !mem_rvalid) || mem_req;
  end

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) $fell(rst) |-> !busy && !done && !found && !mem_req); // R1
  AST_START_LAUNCH: assert property (@(posedge clk) disable iff (rst) start && !busy |=> busy && !done && mem_req && mem_addr == WIN_BASE); // R2
  AST_REQ_ALIGN: assert property (@(posedge clk) disable iff (rst) mem_req |-> (mem_addr[3:0] == 4'h0 || mem_addr[3:0] == 4'h4) && mem_addr >= WIN_BASE); // R3
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst) mem_req |-> !outstanding_q); // R4
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R4
  AST_FOUND_DONE: assert property (@(posedge clk) disable iff (rst) found |-> done); // R5
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst) !(busy && done)); // R2
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst) done && !start |=> done && $stable(found) && $stable(match_addr) && $stable(table_ptr)); // R9
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst) busy && start && !mem_rvalid |=> busy && !done); // R10
endmodule

bind sigscan_top sigscan_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_BASE(WIN_BASE)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .busy(busy), .done(done), .found(found),
  .match_addr(match_addr), .table_ptr(table_ptr)
);

// File: tb/sigscan_top_bench.sv
`timescale 1ns/1ps
module sigscan_top_bench;
  localparam logic [31:0] SIG = 32'h5F504D5F;
  localparam int NV = 7;

  localparam logic [19:0] V_P0A [NV] = '{20'hF0000, 20'hFFFF0, 20'hF8000, 20'hF4004, 20'hF1230, 20'hF5000, 20'hF7770};
  localparam logic [31:0] V_P0V [NV] = '{SIG, SIG, 32'h5F504D5E, SIG, SIG, SIG, 32'h5F4D505F};
  localparam logic [31:0] V_P0N [NV] = '{32'h000F5A30, 32'h12345678, 32'hAAAA5555, 32'h0BADF00D, 32'hDEADBEEF, 32'h55555555, 32'h77777777};
  localparam logic [19:0] V_P1A [NV] = '{20'h00000, 20'h00000, 20'hF9000, 20'hEFFF0, 20'h00000, 20'hF3000, 20'h00000};
  localparam logic [31:0] V_P1V [NV] = '{32'h0, 32'h0, 32'h5E504D5F, SIG, 32'h0, SIG, 32'h0};
  localparam logic [31:0] V_P1N [NV] = '{32'h0, 32'h0, 32'h0, 32'h11111111, 32'h0, 32'h33333333, 32'h0};
  localparam int          V_LAT [NV] = '{0, 1, 0, 2, 3, 0, 1};
  localparam logic        V_EF  [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic [19:0] V_EA  [NV] = '{20'hF0000, 20'hFFFF0, 20'h0, 20'h0, 20'hF1230, 20'hF3000, 20'h0};
  localparam logic [31:0] V_EP  [NV] = '{32'h000F5A30, 32'h12345678, 32'h0, 32'h0, 32'hDEADBEEF, 32'h33333333, 32'h0};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mem_req, mem_rvalid, busy, done, found;
  logic [19:0] mem_addr, match_addr;
  logic [31:0] mem_rdata, table_ptr;

  int n_checks = 0;
  int n_fails  = 0;

  logic [19:0] p0a = 20'h0, p1a = 20'h0;
  logic [31:0] p0v = 32'h0, p0n = 32'h0, p1v = 32'h0, p1n = 32'h0;
  int          lat = 0;

  int          req_count = 0;
  int          viol = 0;
  logic        pend = 1'b0, outst = 1'b0;
  int          cnt = 0;
  logic [19:0] paddr = 20'h0;

  always #2.5 clk = ~clk;

  sigscan_top u_sigscan_top (
    .clk(clk), .rst(rst), .start(start), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid), .busy(busy), .done(done),
    .found(found), .match_addr(match_addr), .table_ptr(table_ptr)
  );

  function automatic logic [31:0] mem_word(input logic [19:0] a);
    if (a == p0a)          return p0v;
    if (a == p0a + 20'd4)  return p0n;
    if (a == p1a)          return p1v;
    if (a == p1a + 20'd4)  return p1n;
    return {8'hA5, 4'h0, a};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
      pend       <= 1'b0;
      outst      <= 1'b0;
    end else begin
      mem_rvalid <= 1'b0;
      outst <= (outst && !mem_rvalid) || mem_req;
      if (mem_req) begin
        req_count <= req_count + 1;
        if (outst && !mem_rvalid) viol <= viol + 1;
        if (lat == 0) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_word(mem_addr);
        end else begin
          pend  <= 1'b1;
          cnt   <= lat;
          paddr <= mem_addr;
        end
      end else if (pend) begin
        if (cnt == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem_word(paddr);
          pend       <= 1'b0;
        end else begin
          cnt <= cnt - 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  endtask

  task automatic run_scan(input int i, input bit poke);
    int r0, v0, waited;
    p0a = V_P0A[i]; p0v = V_P0V[i]; p0n = V_P0N[i];
    p1a = V_P1A[i]; p1v = V_P1V[i]; p1n = V_P1N[i];
    lat = V_LAT[i];
    @(negedge clk);
    r0 = req_count; v0 = viol;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", 32'(busy), 32'd1);
    chk("R2 done cleared by start", 32'(done), 32'd0);
    chk("R2 first request address", {12'h0, mem_addr}, 32'h000F0000);
    if (poke) begin
      repeat (300) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk("R10 still busy after ignored start", 32'(busy), 32'd1);
    end
    waited = 0;
    while (!done && waited < 40000) begin
      @(negedge clk);
      waited++;
    end
    chk("R7 scan completes", 32'(done), 32'd1);
    chk("R6 R8 found flag", 32'(found), 32'(V_EF[i]));
    if (V_EF[i]) begin
      chk("R5 R6 match address", {12'h0, match_addr}, {12'h0, V_EA[i]});
      chk("R5 table pointer", table_ptr, V_EP[i]);
      chk("R3 R5 read count", 32'(req_count - r0), 32'((V_EA[i] - 20'hF0000) / 16 + 2));
    end else begin
      chk("R7 R3 read count", 32'(req_count - r0), 32'd4096);
    end
    chk("R4 R11 no overlapped request", 32'(viol - v0), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog expired: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic        keep_found;
    logic [19:0] keep_addr;
    logic [31:0] keep_ptr;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 found in reset", 32'(found), 32'd0);
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
    chk("R1 table_ptr in reset", table_ptr, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 idle after reset", {28'h0, busy, done, found, mem_req}, 32'd0);

    for (int i = 0; i < NV; i++) run_scan(i, 1'b0);

    // R9: results held while no start arrives
    keep_found = found; keep_addr = match_addr; keep_ptr = table_ptr;
    repeat (25) @(negedge clk);
    chk("R9 done held", 32'(done), 32'd1);
    chk("R9 found held", 32'(found), 32'(keep_found));
    chk("R9 match address held", {12'h0, match_addr}, {12'h0, keep_addr});
    chk("R9 pointer held", table_ptr, keep_ptr);
    chk("R9 no request while done", 32'(mem_req), 32'd0);

    // R10: start in the middle of a late-hit scan changes nothing
    run_scan(1, 1'b1);

    finish_run();
  end
endmodule